// File: doc/BRIEF.md
# Dual-Edge Serial Frame Loader with Idle-Pulse Latch Detection

This block takes a 208-bit frame from a serial data line and a data clock, capturing one bit on every transition of the data clock, rising or falling. A frame is a 16-bit command word followed by twelve 16-bit channel words. Bits that fall off the far end of the shift register are sent out on a serial output, and the data clock is forwarded, so several loaders can be chained. All inputs are slow compared with the system clock. They pass through synchronizers and are handled entirely in the system clock domain.

Captured data does not reach the outputs until a latch sequence is seen. First the data clock must stay still, at either level, for a programmable number of system clocks. Then a burst of four pulses arrives on the data line. On the second qualifying falling edge of that burst, the command latch and the channel latch load from the shift register, and a one-cycle strobe is raised. While the data clock is idle, the serial output does not carry shifted data. It carries regenerated pulses of fixed width, one for each rising edge on the data line, so that pulse widths do not drift along the chain.

Top module: `dual_edge_frame_loader`

## Requirements
- R1: After a synchronous active-low reset, `sdo`, `dclk_out` and `latch_strobe` are 0, and `cmd_word` and `gs_data` are all zeros.
- R2: Each rising or falling transition of `dclk_in` shifts exactly one bit, the synchronized `din` level, into the register. After 208 transitions the first bit sent sits at bit 207.
- R3: On a latch, `cmd_word` takes register bits 207:192, that is, the first 16 bits of the frame.
- R4: On a latch, `gs_data` takes register bits 191:0. Channel k (k = 0..11) is `gs_data[16k+15:16k]`, so channel 11 is the word sent right after the command and channel 0 is the last word sent.
- R5: Outside latch mode, each data-clock transition drives `sdo` with the bit leaving register bit 207. `dclk_out` repeats the synchronized data clock one system clock after `sdo` changes.
- R6: A latch can only happen once `dclk_in` has been constant for IDLE_CYCLES system clocks. Pulses on `din` before that point do not latch.
- R7: The latch happens on the second qualifying falling edge of `din` after the idle period. `latch_strobe` is high for exactly one cycle. The third and fourth pulses do not latch again.
- R8: A `din` high period shorter than HI_MIN synchronized cycles during the pulse phase aborts the sequence. No latch happens until the data clock moves and a new idle period passes.
- R9: Any `dclk_in` transition restarts the idle count and clears the pulse count, so a sequence broken by clock activity is never completed by later pulses.
- R10: While the data clock has been idle for IDLE_CYCLES, `sdo` is high for exactly REGEN_CYCLES system clocks after each rising edge of `din`, whatever the width of the incoming pulse, and is low otherwise.
- R11: Shifting new data does not change `cmd_word` or `gs_data`. They change only together with `latch_strobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dclk_in | input | 1 | Serial data clock, both edges active |
| din | input | 1 | Serial data and latch pulse line |
| dclk_out | output | 1 | Forwarded data clock for the next device |
| sdo | output | 1 | Shifted-out data, or regenerated latch pulses when idle |
| latch_strobe | output | 1 | One-cycle pulse when the latches load |
| cmd_word | output | 16 | Latched command word |
| gs_data | output | 192 | Latched twelve channel words |

## Verification
The hardest case to reach is a latch sequence that has started correctly but is then spoiled: by a pulse that is too narrow, or by a single data-clock transition after the first valid fall. The stimulus gets there in three steps. It arms the block with a full frame and a long idle period. It then sends either a short pulse or one valid pulse followed by one clock toggle. Finally it waits again and sends a clean burst. The cycle at which the strobe appears, counted in falls driven by the bench, shows whether the abandoned pulse count was cleared. The latched command proves that the extra toggle shifted one more bit into the register.

// File: rtl/dfl_pkg.sv
// Package: default geometry and timing values shared by the loader modules.
package dfl_pkg;
    parameter int unsigned DEF_CMD_W       = 16;     // command word width
    parameter int unsigned DEF_WORD_W      = 16;     // channel word width
    parameter int unsigned DEF_N_CHAN      = 12;     // channel words per frame
    parameter int unsigned DEF_SYNC_STAGES = 2;      // synchronizer depth
    parameter int unsigned DEF_IDLE_CYCLES = 11001;  // >220 us at 50 MHz
    parameter int unsigned DEF_HI_MIN      = 4;      // >=70 ns high at 50 MHz
    parameter int unsigned DEF_REGEN       = 5;      // ~90-100 ns regenerated high
endpackage

// File: rtl/dfl_sync.sv
// Module: dfl_sync
// Purpose: brings one asynchronous line into the system clock domain and keeps
//          the previous synchronized level, so that the consumer can detect edges.
// Assumes: the input stays stable for at least two system clocks per level.
module dfl_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic level,
    output logic prev
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    // Hold the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
endmodule

// File: rtl/dfl_shifter.sv
// Module: dfl_shifter
// Purpose: frame shift register; it moves one bit per data-clock transition and
//          registers the bit that leaves the top end for the cascade output.
// Assumes: shift_en is a single-cycle pulse per synchronized clock transition.
module dfl_shifter #(
    parameter int unsigned FRAME_W = 208
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               bit_in,
    output logic [FRAME_W-1:0] sreg,
    output logic               tail_q
);
    // Shift in at bit 0; the oldest bit leaves at the top into tail_q.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg   <= '0;
            tail_q <= 1'b0;
        end else if (shift_en) begin
            tail_q <= sreg[FRAME_W-1];
            sreg   <= {sreg[FRAME_W-2:0], bit_in};
        end
    end

    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !shift_en |=> $stable(sreg)); // R2
    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) shift_en |=> sreg[0] == $past(bit_in)); // R2
endmodule

// File: rtl/dfl_latch_ctrl.sv
// Module: dfl_latch_ctrl
// Purpose: watches for data-clock idle followed by a pulse burst on the data
//          line, issues the latch load and strobe, and regenerates the burst's
//          pulses at a fixed width for the cascade output.
// Assumes: synchronized inputs; low time between pulses is the sender's duty.
module dfl_latch_ctrl #(
    parameter int unsigned IDLE_CYCLES = 11001,
    parameter int unsigned HI_MIN      = 4,
    parameter int unsigned REGEN       = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_edge,
    input  logic din_level,
    input  logic din_prev,
    output logic load_now,
    output logic strobe,
    output logic regen_mode,
    output logic regen_high
);
    localparam int unsigned IDLE_W = $clog2(IDLE_CYCLES + 1);
    localparam int unsigned HI_W   = $clog2(HI_MIN + 1);
    localparam int unsigned RG_W   = $clog2(REGEN + 1);
    localparam logic [IDLE_W-1:0] IDLE_V = IDLE_W'(IDLE_CYCLES);
    localparam logic [HI_W-1:0]   HI_V   = HI_W'(HI_MIN);
    localparam logic [RG_W-1:0]   RG_V   = RG_W'(REGEN);

    logic [IDLE_W-1:0] idle_cnt;
    logic [HI_W-1:0]   hi_cnt;
    logic [RG_W-1:0]   regen_cnt;
    logic [1:0]        pulse_cnt;
    logic              spent;
    logic              at_idle, armed, hi_ok, din_rise, din_fall;

    assign at_idle  = (idle_cnt == IDLE_V);
    assign armed    = at_idle && !spent;
    assign hi_ok    = (hi_cnt >= HI_V);
    assign din_rise = din_level && !din_prev;
    assign din_fall = !din_level && din_prev;
    assign load_now = armed && !clk_edge && din_fall && hi_ok && (pulse_cnt == 2'd1);

    // Count system clocks since the last data-clock transition, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)        idle_cnt <= '0;
        else if (clk_edge) idle_cnt <= '0;
        else if (!at_idle) idle_cnt <= idle_cnt + 1'b1;
    end

    // Measure the current high time of the data line, saturating at the minimum.
    always_ff @(posedge clk) begin
        if (!rst_n)          hi_cnt <= '0;
        else if (!din_level) hi_cnt <= '0;
        else if (!hi_ok)     hi_cnt <= hi_cnt + 1'b1;
    end

    // Track qualifying falls; finish or abort the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_cnt <= 2'd0;
            spent     <= 1'b0;
        end else if (clk_edge) begin
            pulse_cnt <= 2'd0;
            spent     <= 1'b0;
        end else if (armed && din_fall) begin
            if (!hi_ok || pulse_cnt == 2'd3) begin
                pulse_cnt <= 2'd0;
                spent     <= 1'b1;
            end else begin
                pulse_cnt <= pulse_cnt + 2'd1;
            end
        end
    end

    // Register the one-cycle latch strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe <= 1'b0;
        else        strobe <= load_now;
    end

    // Produce a fixed-width pulse for each data-line rise while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                  regen_cnt <= '0;
        else if (at_idle && din_rise) regen_cnt <= RG_V;
        else if (regen_cnt != '0)    regen_cnt <= regen_cnt - 1'b1;
    end

    assign regen_mode = at_idle;
    assign regen_high = (regen_cnt != '0);

    AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n) clk_edge |=> idle_cnt == '0); // R9
    AST_STROBE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n) strobe |-> $past(at_idle)); // R6
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) strobe |=> !strobe); // R7
    AST_SHORT_ABORTS: assert property (@(posedge clk) disable iff (!rst_n) (armed && din_fall && !hi_ok && !clk_edge) |=> !armed); // R8
    AST_REGEN_FROM_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(regen_high) |-> $past(din_rise)); // R10
endmodule

// File: rtl/dual_edge_frame_loader.sv
// Module: dual_edge_frame_loader
// Purpose: top of the serial frame loader; synchronizes the data clock and data
//          line, shifts frames on both clock edges, holds the command and
//          channel latches, and drives the cascade outputs.
// Assumes: data clock and data line are slow against clk (several clocks per level).
module dual_edge_frame_loader
    import dfl_pkg::*;
#(
    parameter int unsigned CMD_W       = DEF_CMD_W,
    parameter int unsigned WORD_W      = DEF_WORD_W,
    parameter int unsigned N_CHAN      = DEF_N_CHAN,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
    parameter int unsigned IDLE_CYCLES = DEF_IDLE_CYCLES,
    parameter int unsigned HI_MIN      = DEF_HI_MIN,
    parameter int unsigned REGEN       = DEF_REGEN,
    localparam int unsigned GS_W       = WORD_W * N_CHAN,
    localparam int unsigned FRAME_W    = CMD_W + GS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dclk_in,
    input  logic            din,
    output logic            dclk_out,
    output logic            sdo,
    output logic            latch_strobe,
    output logic [CMD_W-1:0] cmd_word,
    output logic [GS_W-1:0]  gs_data
);
    logic               ck_level, ck_prev, d_level, d_prev, ck_edge;
    logic [FRAME_W-1:0] sreg;
    logic               sdo_shift, load_now, regen_mode, regen_high;

    dfl_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .d(dclk_in), .level(ck_level), .prev(ck_prev));

    dfl_sync #(.STAGES(SYNC_STAGES)) u_sync_din (
        .clk(clk), .rst_n(rst_n), .d(din), .level(d_level), .prev(d_prev));

    assign ck_edge = ck_level ^ ck_prev;

    dfl_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(ck_edge), .bit_in(d_level),
        .sreg(sreg), .tail_q(sdo_shift));

    dfl_latch_ctrl #(.IDLE_CYCLES(IDLE_CYCLES), .HI_MIN(HI_MIN), .REGEN(REGEN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .clk_edge(ck_edge), .din_level(d_level),
        .din_prev(d_prev), .load_now(load_now), .strobe(latch_strobe),
        .regen_mode(regen_mode), .regen_high(regen_high));

    // Load command and channel latches from the frame register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_word <= '0;
            gs_data  <= '0;
        end else if (load_now) begin
            cmd_word <= sreg[FRAME_W-1 -: CMD_W];
            gs_data  <= sreg[GS_W-1:0];
        end
    end

    // Forward the data clock one cycle behind the shifted-out bit.
    always_ff @(posedge clk) begin
        if (!rst_n) dclk_out <= 1'b0;
        else        dclk_out <= ck_prev;
    end

    assign sdo = regen_mode ? regen_high : sdo_shift;

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !latch_strobe |-> ($stable(cmd_word) && $stable(gs_data))); // R11
    AST_CMD_FROM_TOP: assert property (@(posedge clk) disable iff (!rst_n) latch_strobe |-> cmd_word == $past(sreg[FRAME_W-1 -: CMD_W])); // R3
    AST_GS_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n) latch_strobe |-> gs_data == $past(sreg[GS_W-1:0])); // R4
endmodule

// File: tb/dual_edge_frame_loader_bench.sv
module dual_edge_frame_loader_bench;
    localparam int IDLE = 40;
    localparam int HIM  = 4;
    localparam int RG   = 5;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0, dclk_in = 1'b0, din = 1'b0;
    logic dclk_out, sdo, latch_strobe;
    logic [15:0]  cmd_word;
    logic [191:0] gs_data;

    dual_edge_frame_loader #(.IDLE_CYCLES(IDLE), .HI_MIN(HIM), .REGEN(RG)) u_dual_edge_frame_loader (
        .clk(clk), .rst_n(rst_n), .dclk_in(dclk_in), .din(din), .dclk_out(dclk_out),
        .sdo(sdo), .latch_strobe(latch_strobe), .cmd_word(cmd_word), .gs_data(gs_data));

    int checks = 0, fails = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [191:0] act, input logic [191:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising clock.
    logic [207:0] m_sreg = '0;
    logic m_sdo_q = 0, m_dclk_out = 0, m_strobe = 0;
    logic [15:0] m_cmd = '0;
    logic [191:0] m_gs = '0;
    int m_idle = 0, m_hi = 0, m_pulse = 0, m_regen = 0;
    bit m_spent = 0;
    bit hc[$] = '{1'b0, 1'b0, 1'b0};
    bit hd[$] = '{1'b0, 1'b0, 1'b0};

    always @(posedge clk) begin : model
        bit ce, dl, dp, rise, fall, at_idle, armed, hiok, load;
        if (!rst_n) begin
            m_sreg = '0; m_sdo_q = 0; m_dclk_out = 0; m_strobe = 0;
            m_cmd = '0; m_gs = '0; m_idle = 0; m_hi = 0; m_pulse = 0;
            m_regen = 0; m_spent = 0;
            hc = '{1'b0, 1'b0, 1'b0};
            hd = '{1'b0, 1'b0, 1'b0};
        end else begin
            ce = hc[1] != hc[0];
            dl = hd[1]; dp = hd[0];
            rise = dl && !dp; fall = !dl && dp;
            at_idle = (m_idle == IDLE);
            armed = at_idle && !m_spent;
            hiok = (m_hi >= HIM);
            load = armed && !ce && fall && hiok && (m_pulse == 1);
            m_strobe = load;
            if (load) begin m_cmd = m_sreg[207:192]; m_gs = m_sreg[191:0]; end
            m_dclk_out = hc[0];
            if (ce) begin m_sdo_q = m_sreg[207]; m_sreg = {m_sreg[206:0], dl}; end
            if (ce) begin m_pulse = 0; m_spent = 0; end
            else if (armed && fall) begin
                if (!hiok || m_pulse == 3) begin m_pulse = 0; m_spent = 1; end
                else m_pulse++;
            end
            if (!dl) m_hi = 0; else if (m_hi < HIM) m_hi++;
            if (at_idle && rise) m_regen = RG; else if (m_regen > 0) m_regen--;
            if (ce) m_idle = 0; else if (!at_idle) m_idle++;
            hc.push_back(dclk_in); void'(hc.pop_front());
            hd.push_back(din);     void'(hd.pop_front());
        end
    end

    // Compare every output against the model, and record strobes and regenerated pulses.
    int strobe_cnt = 0, falls_driven = 0, falls_at_strobe = -1;
    bit meas = 0; int hi_obs = 0, rise_obs = 0; logic sdo_prev = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic e_sdo;
            e_sdo = (m_idle == IDLE) ? (m_regen != 0) : m_sdo_q;
            chk(sdo === e_sdo, "R5 R10", "sdo vs model", {191'd0, sdo}, {191'd0, e_sdo});
            chk(dclk_out === m_dclk_out, "R5", "dclk_out vs model", {191'd0, dclk_out}, {191'd0, m_dclk_out});
            chk(latch_strobe === m_strobe, "R7", "strobe vs model", {191'd0, latch_strobe}, {191'd0, m_strobe});
            chk(cmd_word === m_cmd, "R3", "cmd vs model", {176'd0, cmd_word}, {176'd0, m_cmd});
            chk(gs_data === m_gs, "R4", "gs vs model", gs_data, m_gs);
            if (latch_strobe) begin strobe_cnt++; falls_at_strobe = falls_driven; end
            if (meas) begin
                if (sdo) hi_obs++;
                if (sdo && !sdo_prev) rise_obs++;
            end
            sdo_prev = sdo;
        end
    end

    task automatic cyc(input int n); repeat (n) @(negedge clk); endtask

    logic [207:0] out_bits;
    task automatic send_bits(input logic [207:0] f);
        for (int i = 207; i >= 0; i--) begin
            din = f[i]; cyc(3);
            dclk_in = ~dclk_in; cyc(3);
            out_bits[i] = sdo;
        end
        din = 1'b0;
    endtask

    task automatic pulses(input int n, input int hi, input int lo);
        for (int p = 0; p < n; p++) begin
            din = 1'b1; cyc(hi);
            din = 1'b0; falls_driven++; cyc(lo);
        end
    endtask

    function automatic logic [207:0] make_frame(input logic [15:0] c, input logic [15:0] seed);
        logic [207:0] f;
        f[207:192] = c;
        for (int k = 0; k < 12; k++) f[16*k +: 16] = seed ^ (16'(k) * 16'h1357);
        return f;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [207:0] fa, fb, fc, fc2;
        fa = make_frame(16'h05A3, 16'hBEEF);
        fb = make_frame(16'h0371, 16'h4C2D);
        fc = make_frame(16'h06E9, 16'h9183);

        cyc(5); rst_n = 1'b1; cyc(2);
        chk(sdo == 1'b0 && dclk_out == 1'b0 && latch_strobe == 1'b0, "R1", "outputs after reset",
            {189'd0, sdo, dclk_out, latch_strobe}, 192'd0);
        chk(cmd_word == 16'd0 && gs_data == '0, "R1", "latches after reset", gs_data, 192'd0);

        // Frame A, then a clean burst with wide highs.
        send_bits(fa);
        chk(cmd_word == 16'd0, "R11", "cmd unchanged by shifting", {176'd0, cmd_word}, 192'd0);
        cyc(IDLE + 6);
        falls_driven = 0; hi_obs = 0; rise_obs = 0; meas = 1;
        pulses(4, 8, 10); cyc(10); meas = 0;
        chk(strobe_cnt == 1, "R7", "one strobe per burst", 192'(strobe_cnt), 192'd1);
        chk(falls_at_strobe == 2, "R7", "strobe on second fall", 192'(falls_at_strobe), 192'd2);
        chk(cmd_word == fa[207:192], "R3", "command word", {176'd0, cmd_word}, {176'd0, fa[207:192]});
        for (int k = 0; k < 12; k++)
            chk(gs_data[16*k +: 16] == fa[16*k +: 16], "R4", $sformatf("channel %0d", k),
                {176'd0, gs_data[16*k +: 16]}, {176'd0, fa[16*k +: 16]});
        chk(hi_obs == 4 * RG, "R10", "regenerated high cycles", 192'(hi_obs), 192'(4 * RG));
        chk(rise_obs == 4, "R10", "regenerated pulse count", 192'(rise_obs), 192'd4);

        // Frame B: frame A leaves on sdo; the pulses arrive too early.
        send_bits(fb);
        chk(out_bits == fa, "R5 R2", "bits shifted out", out_bits[191:0], fa[191:0]);
        chk(cmd_word == fa[207:192], "R11", "cmd held while shifting", {176'd0, cmd_word}, {176'd0, fa[207:192]});
        cyc(5); falls_driven = 0;
        pulses(2, 5, 8);
        chk(strobe_cnt == 1, "R6", "no latch before idle", 192'(strobe_cnt), 192'd1);
        chk(cmd_word == fa[207:192], "R6", "cmd after early pulses", {176'd0, cmd_word}, {176'd0, fa[207:192]});
        cyc(IDLE + 6); falls_driven = 0;
        pulses(4, 5, 10);
        chk(strobe_cnt == 2, "R6", "latch after idle", 192'(strobe_cnt), 192'd2);
        chk(cmd_word == fb[207:192], "R6", "cmd after idle", {176'd0, cmd_word}, {176'd0, fb[207:192]});

        // Frame C: a narrow pulse aborts the sequence.
        send_bits(fc);
        cyc(IDLE + 6); falls_driven = 0;
        pulses(1, 2, 10);
        pulses(4, 6, 10);
        chk(strobe_cnt == 2, "R8", "short pulse aborts", 192'(strobe_cnt), 192'd2);
        chk(cmd_word == fb[207:192], "R8", "cmd held after abort", {176'd0, cmd_word}, {176'd0, fb[207:192]});

        // Clock activity breaks a started sequence.
        din = 1'b1; cyc(3); dclk_in = ~dclk_in; cyc(3); din = 1'b0;
        cyc(IDLE + 6); falls_driven = 0;
        pulses(1, 6, 10);
        dclk_in = ~dclk_in; cyc(3);
        cyc(IDLE + 6); falls_driven = 0;
        pulses(4, 6, 10);
        fc2 = {fc[205:0], 2'b10};
        chk(strobe_cnt == 3, "R9", "one latch after restart", 192'(strobe_cnt), 192'd3);
        chk(falls_at_strobe == 2, "R9", "count cleared by clock edge", 192'(falls_at_strobe), 192'd2);
        chk(cmd_word == fc2[207:192], "R9 R2", "cmd after extra shifts", {176'd0, cmd_word}, {176'd0, fc2[207:192]});

        cyc(5);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule